// File: doc/BRIEF.md
# Dual-Rail Supply Selection Controller

This block decides, from the audio stream itself, whether a switching output stage should draw from its low-voltage rail or its high-voltage rail. Each valid signed sample is reduced to its magnitude. The magnitude is compared against a programmable threshold and against that threshold widened by a separate hysteresis margin. Quiet material moves the stage onto the low rail only after a dwell timer has seen the level stay below the threshold for the whole programmed time. Loud material brings the stage back to the high rail on the very next clock edge.

The configuration values are plain input ports. The values to apply after power-up are:

- dual-rail mode on;
- threshold 0x50A3D7;
- margin 0x00DA74;
- dwell field 01.

Dwell times are turned into clock-cycle counts from the `CLK_HZ` parameter. Each count is rounded up, so the real dwell is never shorter than the programmed one. A one-cycle pulse marks every rail change, so that a downstream modulator can align to it. A busy flag shows that the dwell timer is running.

Top module: `rail_selector`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rail_low`, `rail_switch` and `dwell_busy` are all 0. A value of 0 on `rail_low` means the high rail.
- R2: The level of a sample is the absolute value of `smp_data` read as 24-bit two's complement. The most negative code 0x800000 has level 8388608.
- R3: The dwell timer starts on a clock edge where all of the following hold: `dual_en` is 1, the high rail is selected, the timer is idle, `smp_valid` is 1 and the level is strictly below `thr_lvl`. `dwell_busy` reads 1 after that edge. Sample data presented with `smp_valid` at 0 is ignored.
- R4: If no valid sample with level at or above `thr_lvl` arrives, `rail_low` becomes 1 exactly T clock edges after the start edge, and `dwell_busy` drops at that same edge. T is ceil(CLK_HZ × t), where t is 100 µs, 500 µs, 5 ms or 50 ms for `dwell_sel` = 00, 01, 10 or 11.
- R5: A valid sample with level at or above `thr_lvl` while the timer runs stops the timer at that edge. The high rail stays selected.
- R6: While the low rail is selected, a valid sample with level strictly greater than `thr_lvl` + `hyst_lvl` returns `rail_low` to 0 at that edge. A sample at or below that sum keeps the low rail. The sum is formed with 25 bits, so it never wraps.
- R7: With `dual_en` at 0, `rail_low` is 0 from the next edge on. The timer is idle and no sample starts it.
- R8: A change of `dual_en` or `dwell_sel` while the timer runs restarts its count from zero at that edge. The new dwell time applies from that edge on.
- R9: `rail_switch` is 1 for exactly the cycle after each edge where `rail_low` changes, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed audio sample |
| dual_en | input | 1 | 1 enables dual-rail operation |
| thr_lvl | input | 24 | Level threshold |
| hyst_lvl | input | 24 | Return hysteresis margin |
| dwell_sel | input | 2 | Dwell time code |
| rail_low | output | 1 | 1 selects the low-voltage rail |
| rail_switch | output | 1 | One-cycle pulse on each rail change |
| dwell_busy | output | 1 | Dwell timer running |

## Verification
Every dwell code is run to completion, with each cycle of the wait checked. This separates an off-by-one count or a missing round-up from a correct one. Magnitudes are swept a few steps either side of the threshold in both signs, which exposes strict-versus-inclusive compare errors and sign-handling errors. It also covers the most negative code and a saturated threshold plus margin, which exposes wraparound of the sum. Aborts, disable during a wait, and a dwell-code change part-way through a wait show that the timer is cleared or restarted, and not merely paused.

// File: rtl/rail_selector.sv
module rail_selector #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned DW     = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          dual_en,
  input  logic [DW-1:0] thr_lvl,
  input  logic [DW-1:0] hyst_lvl,
  input  logic [1:0]    dwell_sel,
  output logic          rail_low,
  output logic          rail_switch,
  output logic          dwell_busy
);

  localparam longint unsigned T_A = (64'(CLK_HZ) * 64'd100   + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned T_B = (64'(CLK_HZ) * 64'd500   + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned T_C = (64'(CLK_HZ) * 64'd5000  + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned T_D = (64'(CLK_HZ) * 64'd50000 + 64'd999_999) / 64'd1_000_000;
  localparam int CW = $clog2(T_D + 1);

  logic [DW-1:0] level;
  logic [DW:0]   exit_lvl;
  logic          is_below, is_over;
  logic [CW-1:0] cnt, cnt_nx, limit;
  logic          low_nx, busy_nx;
  logic          en_q;
  logic [1:0]    sel_q;
  logic          cfg_chg;

  assign level    = smp_data[DW-1] ? (~smp_data + 1'b1) : smp_data;
  assign exit_lvl = {1'b0, thr_lvl} + {1'b0, hyst_lvl};
  assign is_below = level < thr_lvl;
  assign is_over  = {1'b0, level} > exit_lvl;
  assign cfg_chg  = (dual_en != en_q) || (dwell_sel != sel_q);

  always_comb begin
    case (dwell_sel)
      2'b00:   limit = CW'(T_A - 1);
      2'b01:   limit = CW'(T_B - 1);
      2'b10:   limit = CW'(T_C - 1);
      default: limit = CW'(T_D - 1);
    endcase
  end

  always_comb begin
    low_nx  = rail_low;
    busy_nx = dwell_busy;
    cnt_nx  = cnt;
    if (!dual_en) begin
      low_nx  = 1'b0;
      busy_nx = 1'b0;
      cnt_nx  = '0;
    end else if (rail_low) begin
      if (smp_valid && is_over) low_nx = 1'b0;
    end else if (dwell_busy) begin
      if (smp_valid && !is_below) begin
        busy_nx = 1'b0;
        cnt_nx  = '0;
      end else if (cfg_chg) begin
        cnt_nx = '0;
      end else if (cnt == limit) begin
        busy_nx = 1'b0;
        cnt_nx  = '0;
        low_nx  = 1'b1;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end else if (smp_valid && is_below) begin
      busy_nx = 1'b1;
      cnt_nx  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_low    <= 1'b0;
      rail_switch <= 1'b0;
      dwell_busy  <= 1'b0;
      cnt         <= '0;
      en_q        <= 1'b1;
      sel_q       <= 2'b01;
    end else begin
      rail_low    <= low_nx;
      rail_switch <= low_nx != rail_low;
      dwell_busy  <= busy_nx;
      cnt         <= cnt_nx;
      en_q        <= dual_en;
      sel_q       <= dwell_sel;
    end
  end

endmodule

// File: rtl/rail_selector_chk.sv
module rail_selector_chk #(
  parameter int unsigned DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic          dual_en,
  input logic [DW-1:0] thr_lvl,
  input logic [DW-1:0] hyst_lvl,
  input logic          rail_low,
  input logic          rail_switch,
  input logic          dwell_busy
);

  logic [DW:0] mag;
  assign mag = smp_data[DW-1] ? ({1'b0, ~smp_data} + 1'b1) : {1'b0, smp_data};

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en && !rail_low && !dwell_busy && smp_valid && (mag < {1'b0, thr_lvl}) |=> dwell_busy);

  p_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_low) |-> $past(dwell_busy));

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dwell_busy && rail_low));

  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en && dwell_busy && smp_valid && (mag >= {1'b0, thr_lvl}) |=> !dwell_busy && !rail_low);

  p_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en && rail_low && smp_valid && (mag > {1'b0, thr_lvl} + {1'b0, hyst_lvl}) |=> !rail_low);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en && rail_low && !(smp_valid && (mag > {1'b0, thr_lvl} + {1'b0, hyst_lvl})) |=> rail_low);

  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |=> !rail_low && !dwell_busy);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rail_switch == (rail_low != $past(rail_low)));

endmodule

bind rail_selector rail_selector_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .dual_en(dual_en), .thr_lvl(thr_lvl), .hyst_lvl(hyst_lvl),
  .rail_low(rail_low), .rail_switch(rail_switch), .dwell_busy(dwell_busy)
);

// File: tb/rail_selector_test.sv
module rail_selector_test;
  localparam int unsigned FCLK = 123_457;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic dual_en = 1'b1;
  logic [23:0] thr_lvl = 24'd1000, hyst_lvl = 24'd200;
  logic [1:0] dwell_sel = 2'b01;
  logic rail_low, rail_switch, dwell_busy;
  int nvec = 0, nfail = 0;

  rail_selector #(.CLK_HZ(FCLK)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .dual_en(dual_en), .thr_lvl(thr_lvl), .hyst_lvl(hyst_lvl), .dwell_sel(dwell_sel),
    .rail_low(rail_low), .rail_switch(rail_switch), .dwell_busy(dwell_busy)
  );

  always #2 clk = ~clk;

  function automatic int dwell_cycles(int code);
    longint us;
    us = (code == 0) ? 100 : (code == 1) ? 500 : (code == 2) ? 5000 : 50000;
    return int'((longint'(FCLK) * us + 999_999) / 1_000_000);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(int v);
    smp_valid = 1'b1;
    smp_data  = 24'(v);
    tick();
    smp_valid = 1'b0;
    smp_data  = '0;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic chk3(string req, logic lo, logic sw, logic bz);
    chk(req, "rail_low", rail_low, lo);
    chk(req, "rail_switch", rail_switch, sw);
    chk(req, "dwell_busy", dwell_busy, bz);
  endtask

  initial begin
    #600_000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int t;
    repeat (3) tick();
    chk3("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick();
    chk3("R1", 1'b0, 1'b0, 1'b0);

    // R3 ignored data, R4 dwell per code, R6 return, R9 pulses
    for (int s = 0; s < 4; s++) begin
      dwell_sel = 2'(s);
      tick();
      smp_data = 24'(-5);
      repeat (3) tick();
      chk3("R3", 1'b0, 1'b0, 1'b0);
      t = dwell_cycles(s);
      put(-500);
      chk3("R3", 1'b0, 1'b0, 1'b1);
      for (int k = 1; k < t; k++) begin
        tick();
        chk("R4", "rail_low during dwell", rail_low, 1'b0);
      end
      tick();
      chk3("R4", 1'b1, 1'b1, 1'b0);
      tick();
      chk3("R9", 1'b1, 1'b0, 1'b0);
      put(1200);
      chk3("R6", 1'b1, 1'b0, 1'b0);
      put(-1200);
      chk3("R6", 1'b1, 1'b0, 1'b0);
      put((s % 2) ? 1201 : -1201);
      chk3("R6", 1'b0, 1'b1, 1'b0);
      tick();
      chk3("R9", 1'b0, 1'b0, 1'b0);
    end

    // R5 abort
    dwell_sel = 2'b00;
    tick();
    put(3);
    chk3("R5", 1'b0, 1'b0, 1'b1);
    repeat (5) tick();
    put(999);
    chk3("R5", 1'b0, 1'b0, 1'b1);
    put(-1000);
    chk3("R5", 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++) begin
      tick();
      chk("R5", "rail_low after abort", rail_low, 1'b0);
    end

    // R2 magnitude sweep around threshold
    for (int d = -3; d <= 3; d++) begin
      for (int sg = 0; sg < 2; sg++) begin
        put(sg ? -(1000 + d) : (1000 + d));
        chk("R2", "dwell_busy vs magnitude", dwell_busy, (1000 + d) < 1000);
        if (dwell_busy) begin
          put(5000);
          chk("R5", "dwell_busy after abort", dwell_busy, 1'b0);
        end
      end
    end
    thr_lvl = 24'h7FFFFF;
    put(-8388608);
    chk("R2", "most negative vs 0x7FFFFF", dwell_busy, 1'b0);
    thr_lvl = 24'hFFFFFF;
    hyst_lvl = 24'hFFFFFF;
    put(-8388608);
    chk("R2", "most negative vs 0xFFFFFF", dwell_busy, 1'b1);
    t = dwell_cycles(0);
    repeat (t - 1) tick();
    chk("R4", "rail_low before end", rail_low, 1'b0);
    tick();
    chk("R4", "rail_low at end", rail_low, 1'b1);
    put(-8388608);
    chk("R6", "no wrap of sum", rail_low, 1'b1);
    put(24'h7FFFFF);
    chk("R6", "no wrap of sum", rail_low, 1'b1);

    // R7 disable
    dual_en = 1'b0;
    tick();
    chk3("R7", 1'b0, 1'b1, 1'b0);
    thr_lvl = 24'd1000;
    hyst_lvl = 24'd200;
    put(0);
    chk3("R7", 1'b0, 1'b0, 1'b0);
    repeat (30) tick();
    chk3("R7", 1'b0, 1'b0, 1'b0);
    dual_en = 1'b1;
    tick();
    put(0);
    chk3("R3", 1'b0, 1'b0, 1'b1);
    repeat (3) tick();
    dual_en = 1'b0;
    tick();
    chk3("R7", 1'b0, 1'b0, 1'b0);
    dual_en = 1'b1;
    repeat (20) tick();
    chk3("R7", 1'b0, 1'b0, 1'b0);

    // R8 dwell code change restarts count
    put(0);
    chk3("R8", 1'b0, 1'b0, 1'b1);
    repeat (7) tick();
    dwell_sel = 2'b01;
    tick();
    t = dwell_cycles(1);
    for (int k = 1; k < t; k++) begin
      tick();
      chk("R8", "rail_low after restart", rail_low, 1'b0);
    end
    tick();
    chk3("R8", 1'b1, 1'b1, 1'b0);
    put(-99999);
    chk3("R6", 1'b0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule